// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Port

This block holds the settings that steer a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test select. Settings reach it by one of two routes. On the parallel route, a level strobe makes the divide pins transparent while it is low and freezes them once it goes high. On the serial route, a frame is shifted in on a slow shift clock and handed over by a load strobe. While that strobe is high, every shift is copied straight into the live settings.

All strobes and pins are resampled in one system clock domain through a synchronizer chain. Strobe edges are then found by comparing each synchronized strobe with its previous value. The stored test select picks the source for a debug output. That output is silenced whenever the parallel route is transparent. A range flag reports whether the live feedback divide value lies inside a parameterised lock window, 25 to 31 by default.

Top module: `synth_cfg_port`

## Requirements
- R1: While the power-on reset is low, the live feedback and output divide values take the parallel pin values and the test select is cleared to 00.
- R2: While `par_latch` is low, `m_act` and `n_act` follow `m_pin` and `n_pin` three system clock edges after a pin change.
- R3: Once `par_latch` is high, later changes on `m_pin` and `n_pin` leave `m_act` and `n_act` unchanged.
- R4: With `par_latch` high, each rising edge of `ser_clk` shifts in `ser_din`. A frame is 14 bits sent in this order: feedback bits 0 to 8, output code bits 0 and 1, one unused slot, then test bits 0 and 1. The unused slot reaches no output. Shifting while `ser_ld` stays low does not change the live values.
- R5: A rising edge of `ser_ld` copies the frame into `m_act`, `n_act` and `t_sel`. After `ser_ld` falls, further shifting leaves them unchanged.
- R6: While `ser_ld` is held high, each shift also copies the updated shift register into the live values.
- R7: With `par_latch` high, `test_out` is 0 for test select 00, `ser_din` for 01, `fb_div_in` for 10 and `fout_in` for 11.
- R8: While `par_latch` is low, `test_out` is 0 whatever the test select.
- R9: `mr` leaves `m_act`, `n_act` and `t_sel` unchanged. While `mr` is high, `test_out` is 0 when the test select is 10 or 11.
- R10: `m_ok` is 1 exactly when `m_act` lies within `M_LO`..`M_HI` inclusive (25 and 31 by default).
- R11: When `par_latch` returns low after serial loading, the pins again drive the divide values and `t_sel` keeps its serially loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control input |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| mr | input | 1 | Master reset of the downstream dividers; gates divider-derived test sources |
| par_latch | input | 1 | Parallel strobe: 0 makes the pins transparent, 1 holds them and enables serial mode |
| m_pin | input | 9 | Parallel feedback divide value |
| n_pin | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock, sampled in the system domain |
| ser_din | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load strobe |
| fb_div_in | input | 1 | Feedback divider output, offered to the test mux |
| fout_in | input | 1 | Synthesized output clock, offered to the test mux |
| m_act | output | 9 | Live feedback divide value |
| n_act | output | 2 | Live output divide code |
| t_sel | output | 2 | Live test select |
| test_out | output | 1 | Debug observation output |
| m_ok | output | 1 | Live feedback value lies in the lock window |

## Verification
A shift register out of step by one slot shows up as a different feedback value, output code and test select once the next load strobe copies it out. If it is driven with the strobe held high, the error appears after a single shift. A missed or doubled edge detect shows up as a live value that moves when it should hold, or holds when it should move. That becomes visible three system clocks after the strobe or shift edge. A wrong test select shows at once on `test_out` when its source input is toggled, with no clock edge needed.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  typedef enum logic [1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDI   = 2'b01,
    TSEL_FBDIV = 2'b10,
    TSEL_FOUT  = 2'b11
  } tsel_e;

  // Serial frame: feedback bits, output code bits, one empty slot, two test bits.
  function automatic int unsigned frame_len(input int unsigned mw, input int unsigned nw,
                                            input int unsigned tw);
    return mw + nw + 1 + tw;
  endfunction

  function automatic logic m_within(input int unsigned m, input int unsigned lo,
                                    input int unsigned hi);
    return (m >= lo) && (m <= hi);
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 1) begin : g_one
      logic [W-1:0] stg;
      always_ff @(posedge clk) stg <= d;
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      // reset preloads every stage with the live input so no false edge appears
      always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{d}};
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [M_W-1:0] cur_m,
  output logic [N_W-1:0] cur_n,
  output logic [T_W-1:0] cur_t,
  output logic [M_W-1:0] nxt_m,
  output logic [N_W-1:0] nxt_n,
  output logic [T_W-1:0] nxt_t
);
  localparam int F     = synth_cfg_pkg::frame_len(M_W, N_W, T_W);
  localparam int N_LSB = M_W;
  localparam int T_LSB = F - T_W;

  logic [F-1:0] sr;

  // newest bit enters at the top, so the first bit sent ends in bit 0
  always_ff @(posedge clk) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= {din, sr[F-1:1]};
  end

  assign cur_m = sr[M_W-1:0];
  assign cur_n = sr[N_LSB +: N_W];
  assign cur_t = sr[T_LSB +: T_W];
  assign nxt_m = sr[M_W:1];
  assign nxt_n = sr[N_LSB+1 +: N_W];
  assign nxt_t = {din, sr[F-1 -: T_W-1]};

  // R4
  shift_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr[F-1] == $past(din));
  // R5
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] raw_m,
  input  logic [N_W-1:0] raw_n,
  input  logic           xpar,
  input  logic [M_W-1:0] pin_m,
  input  logic [N_W-1:0] pin_n,
  input  logic           ld_frame,
  input  logic           ld_live,
  input  logic [M_W-1:0] cur_m,
  input  logic [N_W-1:0] cur_n,
  input  logic [T_W-1:0] cur_t,
  input  logic [M_W-1:0] nxt_m,
  input  logic [N_W-1:0] nxt_n,
  input  logic [T_W-1:0] nxt_t,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q <= raw_m;
      n_q <= raw_n;
      t_q <= '0;
    end else if (xpar) begin
      m_q <= pin_m;
      n_q <= pin_n;
    end else if (ld_live) begin
      m_q <= nxt_m;
      n_q <= nxt_n;
      t_q <= nxt_t;
    end else if (ld_frame) begin
      m_q <= cur_m;
      n_q <= cur_n;
      t_q <= cur_t;
    end
  end

  // R2
  par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xpar |=> (m_q == $past(pin_m)) && (n_q == $past(pin_n)));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xpar && !ld_frame && !ld_live) |=> $stable(m_q) && $stable(n_q) && $stable(t_q));
  // R11
  par_keeps_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xpar |=> $stable(t_q));
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int M_LO        = 25,
  parameter int M_HI        = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           par_latch,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           ser_ld,
  input  logic           fb_div_in,
  input  logic           fout_in,
  output logic [M_W-1:0] m_act,
  output logic [N_W-1:0] n_act,
  output logic [1:0]     t_sel,
  output logic           test_out,
  output logic           m_ok
);
  import synth_cfg_pkg::*;

  localparam int T_W    = 2;
  localparam int SYNC_W = M_W + N_W + 4;
  localparam int B_SDI  = M_W + N_W;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic [M_W-1:0]    m_s;
  logic [N_W-1:0]    n_s;
  logic              sdi_s, sck_s, sld_s, plat_s;
  logic [1:0]        strb_q;
  logic              sck_rise, sld_rise;
  logic              xpar, shift_ev, ld_frame, ld_live;
  logic [M_W-1:0]    cur_m, nxt_m;
  logic [N_W-1:0]    cur_n, nxt_n;
  logic [T_W-1:0]    cur_t, nxt_t;

  assign raw_bus = {par_latch, ser_ld, ser_clk, ser_din, n_pin, m_pin};

  cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign m_s    = sync_bus[M_W-1:0];
  assign n_s    = sync_bus[M_W +: N_W];
  assign sdi_s  = sync_bus[B_SDI];
  assign sck_s  = sync_bus[B_SDI+1];
  assign sld_s  = sync_bus[B_SDI+2];
  assign plat_s = sync_bus[B_SDI+3];

  always_ff @(posedge clk) strb_q <= {sld_s, sck_s};

  // named internal events
  assign sck_rise = sck_s & ~strb_q[0];
  assign sld_rise = sld_s & ~strb_q[1];
  assign xpar     = ~plat_s;
  assign shift_ev = plat_s & sck_rise;
  assign ld_frame = plat_s & sld_rise;
  assign ld_live  = plat_s & sld_s & sck_rise;

  cfg_shift #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_ev), .din(sdi_s),
    .cur_m(cur_m), .cur_n(cur_n), .cur_t(cur_t),
    .nxt_m(nxt_m), .nxt_n(nxt_n), .nxt_t(nxt_t)
  );

  cfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .raw_m(m_pin), .raw_n(n_pin),
    .xpar(xpar), .pin_m(m_s), .pin_n(n_s),
    .ld_frame(ld_frame), .ld_live(ld_live),
    .cur_m(cur_m), .cur_n(cur_n), .cur_t(cur_t),
    .nxt_m(nxt_m), .nxt_n(nxt_n), .nxt_t(nxt_t),
    .m_q(m_act), .n_q(n_act), .t_q(t_sel)
  );

  always_comb begin
    test_out = 1'b0;
    if (plat_s) begin
      unique case (tsel_e'(t_sel))
        TSEL_LOW:   test_out = 1'b0;
        TSEL_SDI:   test_out = ser_din;
        TSEL_FBDIV: test_out = fb_div_in & ~mr;
        TSEL_FOUT:  test_out = fout_in & ~mr;
      endcase
    end
  end

  assign m_ok = m_within(32'(m_act), M_LO, M_HI);

  // R8
  par_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xpar |-> !test_out);
  // R9
  mr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr && t_sel[1]) |-> !test_out);
  // R10
  range_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(m_act) < M_LO) |-> !m_ok);
  // R10
  range_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(m_act) > M_HI) |-> !m_ok);
endmodule

// File: tb/sim_synth_cfg_port.sv
`timescale 1ns/1ps
module sim_synth_cfg_port;
  logic clk = 1'b0;
  logic rst_n, mr, par_latch, ser_clk, ser_din, ser_ld, fb_div_in, fout_in;
  logic [8:0] m_pin;
  logic [1:0] n_pin;
  logic [8:0] m_act;
  logic [1:0] n_act, t_sel;
  logic test_out, m_ok;

  always #10 clk = ~clk;

  synth_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .mr(mr), .par_latch(par_latch), .m_pin(m_pin), .n_pin(n_pin),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_ld(ser_ld), .fb_div_in(fb_div_in),
    .fout_in(fout_in), .m_act(m_act), .n_act(n_act), .t_sel(t_sel),
    .test_out(test_out), .m_ok(m_ok)
  );

  typedef struct {
    string      tag;
    logic [8:0] m;
    logic [1:0] n;
    logic [1:0] t;
    logic       tst;
    logic       ok;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int compared = 0, mismatched = 0;
  logic [13:0] exp_sr = '0;
  logic [8:0] em;
  logic [1:0] en, et;

  function automatic logic lock_ok(input logic [8:0] m);
    return (m > 9'd24) && (m < 9'd32);
  endfunction

  function automatic logic test_model();
    if (!par_latch) return 1'b0;
    if (et == 2'b00) return 1'b0;
    if (et == 2'b01) return ser_din;
    if (mr) return 1'b0;
    return (et == 2'b10) ? fb_div_in : fout_in;
  endfunction

  task automatic cmp(input string tag, input string fld, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  // monitor: pops each expected item and compares it with the ports
  initial forever begin
    exp_t e;
    @(chk_ev);
    while (q.size() > 0) begin
      e = q.pop_front();
      cmp(e.tag, "m_act", int'(m_act), int'(e.m));
      cmp(e.tag, "n_act", int'(n_act), int'(e.n));
      cmp(e.tag, "t_sel", int'(t_sel), int'(e.t));
      cmp(e.tag, "test_out", int'(test_out), int'(e.tst));
      cmp(e.tag, "m_ok", int'(m_ok), int'(e.ok));
    end
  end

  task automatic expect_now(input string tag);
    exp_t e;
    e.tag = tag; e.m = em; e.n = en; e.t = et; e.tst = test_model(); e.ok = lock_ok(em);
    q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic take_sr();
    em = exp_sr[8:0]; en = exp_sr[10:9]; et = exp_sr[13:12];
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_din = b; ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (5) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    exp_sr = {b, exp_sr[13:1]};
    if (ser_ld) take_sr();
  endtask

  task automatic send_frame(input logic [8:0] m, input logic [1:0] n, input logic nul,
                            input logic [1:0] t);
    for (int i = 0; i < 9; i++) shift_bit(m[i]);
    for (int i = 0; i < 2; i++) shift_bit(n[i]);
    shift_bit(nul);
    for (int i = 0; i < 2; i++) shift_bit(t[i]);
  endtask

  task automatic pulse_load();
    ser_ld = 1'b1; settle(); take_sr();
    ser_ld = 1'b0; settle();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mr = 1'b0; par_latch = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
    ser_ld = 1'b0; fb_div_in = 1'b0; fout_in = 1'b0; m_pin = 9'd28; n_pin = 2'd1;
    repeat (3) @(posedge clk); @(negedge clk);
    em = 9'd28; en = 2'd1; et = 2'd0;
    expect_now("R1 reset loads pins");
    rst_n = 1'b1;

    m_pin = 9'd20; n_pin = 2'd2; settle(); em = 9'd20; en = 2'd2;
    expect_now("R2 transparent, R10 below window");
    m_pin = 9'd31; n_pin = 2'd3; settle(); em = 9'd31; en = 2'd3;
    expect_now("R10 upper bound");
    m_pin = 9'd32; settle(); em = 9'd32;
    expect_now("R10 above window");
    m_pin = 9'd25; settle(); em = 9'd25;
    expect_now("R10 lower bound");

    par_latch = 1'b1; settle();
    m_pin = 9'd300; n_pin = 2'd0; settle();
    expect_now("R3 latched pins ignored");

    send_frame(9'd27, 2'd2, 1'b1, 2'b01);
    expect_now("R4 shift without load");
    pulse_load();
    expect_now("R5 frame loaded, R7 select 01");
    ser_din = 1'b1; #1;
    expect_now("R7 test follows serial data");
    shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    expect_now("R5 held after load strobe fell");

    send_frame(9'd30, 2'd0, 1'b1, 2'b10);
    pulse_load();
    expect_now("R4 R5 second frame, null slot dropped");
    fb_div_in = 1'b1; #1;
    expect_now("R7 test follows feedback divider");

    ser_ld = 1'b1; settle();
    expect_now("R6 load strobe high, no shift yet");
    shift_bit(1'b1);
    expect_now("R6 live update after one shift");
    shift_bit(1'b0);
    expect_now("R6 live update after two shifts");
    ser_ld = 1'b0; settle();

    send_frame(9'd26, 2'd1, 1'b0, 2'b11);
    pulse_load();
    fout_in = 1'b1; #1;
    expect_now("R7 test follows output clock");
    mr = 1'b1; #1;
    expect_now("R9 master reset gates test");
    settle();
    expect_now("R9 master reset keeps settings");
    mr = 1'b0; #1;
    expect_now("R9 release");

    par_latch = 1'b0; m_pin = 9'd29; n_pin = 2'd0; settle();
    em = 9'd29; en = 2'd0;
    expect_now("R8 parallel quiets test, R11 pins resume, select kept");

    settle();
    finish_run();
  end
endmodule